// File: doc/BRIEF.md
# Look-Ahead XY Route Unit with Downstream Wakeup

This block is the route-computation stage of a 2-D mesh router that uses dimension-order XY routing with look-ahead. A header flit arrives already carrying the output port this router must use, because the previous hop computed it. The unit passes that port on and computes the port the next router will take. That second port is written back into the header, so the next router knows its route the moment the flit lands.

The same result drives a one-hot wakeup vector. Its set bit names the direction the packet will leave the next router. The router two hops ahead can therefore power up the channel the packet will enter several cycles before the flit gets there. The source network interface fills in the first port of a fresh packet. Switch allocation and the crossbar sit outside this block.

Headers enter and leave on valid/ready streams. A header is accepted when `in_valid` and `in_ready` are both high. The single output register is loaded on that cycle. It holds its contents while `out_valid` is high and `out_ready` is low, and `in_ready` stays low for as long as that stall lasts. The router coordinates are plain inputs that are expected to stay static.

Top module: `lar_route_unit`

## Requirements
- R1: After reset, and before any header is accepted, `out_valid` is 0 and `wake` is all zeros.
- R2: An accepted header appears on the outputs in the next cycle with `out_valid` high. `out_port` equals the carried `in_port`, and `out_dst_x`/`out_dst_y` equal the input destination.
- R3: Port codes are 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-. The next router sits at the own coordinates stepped one unit by `in_port`: X+ adds 1 to x, X- subtracts 1 from x, Y+ adds 1 to y, Y- subtracts 1 from y. `out_next_port` is XY-routed from that point. If dst_x is greater, the port is 1; if dst_x is smaller, it is 2. Otherwise, if dst_y is greater, the port is 3; if dst_y is smaller, it is 4. If both match, it is 0.
- R4: When `in_port` is 0 (local) or an unused code 5 to 7, `out_next_port` is 0 and `wake` stays all zeros for that header.
- R5: For a header with `in_port` 1 to 4, `wake` shows exactly one set bit, at index `out_next_port`, in the cycle after acceptance. In any cycle after which no header was accepted, `wake` is all zeros.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output field holds its value.
- R7: With `out_ready` held high, a header can be accepted every cycle, and each one produces its own output and wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 2 | This router's x coordinate |
| my_y | input | 2 | This router's y coordinate |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be taken |
| in_dst_x | input | 2 | Destination x |
| in_dst_y | input | 2 | Destination y |
| in_port | input | 3 | Port for this router, carried in the header |
| out_valid | output | 1 | Output header valid |
| out_ready | input | 1 | Downstream accepts output header |
| out_port | output | 3 | Port this router uses |
| out_next_port | output | 3 | Port the next router will use, written into the header |
| out_dst_x | output | 2 | Destination x, passed through |
| out_dst_y | output | 2 | Destination y, passed through |
| wake | output | 5 | One-hot wakeup pulse toward the router two hops ahead, indexed by port code |

## Verification
The checker watches, on every cycle, the stream rules and the shape of the wakeup signal. These are the hold under stall, the low ready during a stall, the one-cycle load latency, the one-hot wake that matches the next port, and a silent wake after idle cycles or local headers. None of these checks can tell whether the XY decision itself is right. The bench sweeps every own position, destination and carried port of the 4x4 mesh, and compares next port and wake against values it computes arithmetically. A directed stall scenario covers back-pressure and confirms the pulse lasts only one cycle.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = 3;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XM    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YM    = 3'd4
  } port_e;
endpackage

// File: rtl/lar_step.sv
// Coordinates of the neighbour reached through a given output port.
module lar_step
  import lar_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic [XW-1:0]     cur_x,
  input  logic [YW-1:0]     cur_y,
  input  logic [PORT_W-1:0] dir,
  output logic [XW-1:0]     nb_x,
  output logic [YW-1:0]     nb_y,
  output logic              moves
);
  always_comb begin
    nb_x  = cur_x;
    nb_y  = cur_y;
    moves = 1'b1;
    unique case (dir)
      PORT_XP: nb_x = cur_x + XW'(1);
      PORT_XM: nb_x = cur_x - XW'(1);
      PORT_YP: nb_y = cur_y + YW'(1);
      PORT_YM: nb_y = cur_y - YW'(1);
      default: moves = 1'b0;
    endcase
  end
endmodule

// File: rtl/lar_xy_pick.sv
// Dimension-order decision: settle X first, then Y, then eject.
module lar_xy_pick
  import lar_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic [XW-1:0]     at_x,
  input  logic [YW-1:0]     at_y,
  input  logic [XW-1:0]     dst_x,
  input  logic [YW-1:0]     dst_y,
  output logic [PORT_W-1:0] pick
);
  always_comb begin
    if (dst_x > at_x)      pick = PORT_XP;
    else if (dst_x < at_x) pick = PORT_XM;
    else if (dst_y > at_y) pick = PORT_YP;
    else if (dst_y < at_y) pick = PORT_YM;
    else                   pick = PORT_LOCAL;
  end
endmodule

// File: rtl/lar_wake_dec.sv
// One-hot decode of a port code, gated by an enable.
module lar_wake_dec
  import lar_pkg::*;
#(
  parameter int N = NPORT
) (
  input  logic              en,
  input  logic [PORT_W-1:0] code,
  output logic [N-1:0]      onehot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign onehot[i] = en && (code == PORT_W'(i));
  end
endmodule

// File: rtl/lar_route_unit.sv
module lar_route_unit
  import lar_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XW-1:0]     my_x,
  input  logic [YW-1:0]     my_y,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XW-1:0]     in_dst_x,
  input  logic [YW-1:0]     in_dst_y,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_port,
  output logic [PORT_W-1:0] out_next_port,
  output logic [XW-1:0]     out_dst_x,
  output logic [YW-1:0]     out_dst_y,
  output logic [NPORT-1:0]  wake
);
  logic [XW-1:0]     nb_x;
  logic [YW-1:0]     nb_y;
  logic              fwd;
  logic [PORT_W-1:0] xy_port;
  logic [PORT_W-1:0] next_c;
  logic [NPORT-1:0]  wake_c;
  logic              take;

  lar_step #(.XW(XW), .YW(YW)) u_step (
    .cur_x(my_x), .cur_y(my_y), .dir(in_port),
    .nb_x(nb_x), .nb_y(nb_y), .moves(fwd)
  );

  lar_xy_pick #(.XW(XW), .YW(YW)) u_pick (
    .at_x(nb_x), .at_y(nb_y), .dst_x(in_dst_x), .dst_y(in_dst_y),
    .pick(xy_port)
  );

  // A header ejecting here has no next router to route for.
  assign next_c = fwd ? xy_port : PORT_LOCAL;

  lar_wake_dec #(.N(NPORT)) u_wdec (
    .en(fwd), .code(next_c), .onehot(wake_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_port      <= PORT_LOCAL;
      out_next_port <= PORT_LOCAL;
      out_dst_x     <= '0;
      out_dst_y     <= '0;
      wake          <= '0;
    end else begin
      wake <= take ? wake_c : '0;
      if (take) begin
        out_valid     <= 1'b1;
        out_port      <= in_port;
        out_next_port <= next_c;
        out_dst_x     <= in_dst_x;
        out_dst_y     <= in_dst_y;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lar_route_chk.sv
module lar_route_chk
  import lar_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [PORT_W-1:0] in_port,
  input logic [XW-1:0]     in_dst_x,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_port,
  input logic [PORT_W-1:0] out_next_port,
  input logic [XW-1:0]     out_dst_x,
  input logic [NPORT-1:0]  wake
);
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_port == $past(in_port) && out_dst_x == $past(in_dst_x)); // R2
  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_port == 3'd0 || in_port > 3'd4) |=> wake == '0 && out_next_port == 3'd0); // R4
  AST_WAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake)); // R5
  AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wake != '0 |-> wake[out_next_port] && out_valid); // R5
  AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> wake == '0); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_next_port) && $stable(out_dst_x)); // R6
  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
endmodule

bind lar_route_unit lar_route_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_port(in_port), .in_dst_x(in_dst_x), .out_valid(out_valid),
  .out_ready(out_ready), .out_port(out_port), .out_next_port(out_next_port),
  .out_dst_x(out_dst_x), .wake(wake)
);

// File: tb/lar_route_unit_tb.sv
module lar_route_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] my_x = '0, my_y = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_dst_x = '0, in_dst_y = '0;
  logic [2:0] in_port = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [2:0] out_port, out_next_port;
  logic [1:0] out_dst_x, out_dst_y;
  logic [4:0] wake;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lar_route_unit u_dut (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_dst_x(in_dst_x),
    .in_dst_y(in_dst_y), .in_port(in_port), .out_valid(out_valid),
    .out_ready(out_ready), .out_port(out_port), .out_next_port(out_next_port),
    .out_dst_x(out_dst_x), .out_dst_y(out_dst_y), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int xy_ref(int ax, int ay, int dx, int dy);
    if (dx > ax) return 1;
    if (dx < ax) return 2;
    if (dy > ay) return 3;
    if (dy < ay) return 4;
    return 0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int nx, ny, en, ew;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(wake == 5'd0, "R1 wake", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && wake == 5'd0, "R1 idle after reset", wake, 0);

    // Full sweep, back-to-back headers (R7)
    for (int mx = 0; mx < 4; mx++)
      for (int my = 0; my < 4; my++)
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 4; dy++)
            for (int p = 0; p < 8; p++) begin
              nx = mx + (p == 1) - (p == 2);
              ny = my + (p == 3) - (p == 4);
              if (nx < 0 || nx > 3 || ny < 0 || ny > 3) continue;
              my_x = 2'(mx); my_y = 2'(my);
              in_dst_x = 2'(dx); in_dst_y = 2'(dy); in_port = 3'(p);
              in_valid = 1'b1;
              chk(in_ready == 1'b1, "R7 ready", in_ready, 1);
              @(negedge clk);
              chk(out_valid && out_port == 3'(p) && out_dst_x == 2'(dx) && out_dst_y == 2'(dy),
                  "R2 passthrough", out_port, p);
              if (p >= 1 && p <= 4) begin
                en = xy_ref(nx, ny, dx, dy);
                ew = 1 << en;
                chk(out_next_port == 3'(en), "R3 next port", out_next_port, en);
                chk(wake == 5'(ew), "R5 wake", wake, ew);
              end else begin
                chk(out_next_port == 3'd0, "R4 next port", out_next_port, 0);
                chk(wake == 5'd0, "R4 wake", wake, 0);
              end
            end
    in_valid = 1'b0;
    @(negedge clk);
    chk(wake == 5'd0, "R5 wake idle", wake, 0);
    chk(out_valid == 1'b0, "R7 drained", out_valid, 0);

    // Stall: (1,1) sending X+ to (2,1), dst (2,3): next port Y+ (3)
    my_x = 2'd1; my_y = 2'd1; in_dst_x = 2'd2; in_dst_y = 2'd3; in_port = 3'd1;
    out_ready = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk(out_next_port == 3'd3 && wake == 5'b01000, "R5 stall load wake", wake, 8);
    chk(in_ready == 1'b0, "R6 ready low", in_ready, 0);
    in_dst_x = 2'd0; in_port = 3'd2; my_x = 2'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_next_port == 3'd3 && out_port == 3'd1 && out_dst_x == 2'd2,
          "R6 hold", out_next_port, 3);
      chk(wake == 5'd0, "R5 single pulse", wake, 0);
      chk(in_ready == 1'b0, "R6 ready held low", in_ready, 0);
    end
    // release: second header (2,1) X- to (1,1), dst (0,3): next X- (2)
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_port == 3'd2 && out_next_port == 3'd2, "R6 after release", out_next_port, 2);
    chk(wake == 5'b00100, "R5 wake after release", wake, 4);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && wake == 5'd0, "R5 quiet", wake, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule